// File: doc/BRIEF.md
# Fibonacci Q-Matrix Block Cipher Core

This core scrambles a block of four W-bit words by treating it as a 2-by-2 matrix P and right-multiplying it by the n-th power of the Fibonacci Q-matrix, Q^n = [[F(n+1), F(n)], [F(n), F(n-1)]]. It unscrambles by right-multiplying by the inverse power, Q^-n = (-1)^n · [[F(n-1), -F(n)], [-F(n), F(n+1)]]. All arithmetic wraps modulo 2^W, so decrypting an encrypted block gives back the original words exactly.

The power n is fixed when the block is built, so every matrix entry is a constant. Each constant product is built from canonical-signed-digit shift-add and shift-subtract terms, worked out by a constant function while the design elaborates. Digits at weight 2^W and above are dropped, because the datapath works modulo 2^W. This keeps the number of partial products small compared with a general multiplier. A word enters with a valid strobe and a direction select, and the result matrix appears one clock later in a register.

Top module: `fqm_cipher`

## Requirements
- R1: During and directly after reset, `res_valid` is 0 and `res_block` is all zeros.
- R2: `res_valid` is 1 exactly in the cycle after a cycle with `req_valid` = 1, and 0 after a cycle with `req_valid` = 0. This holds for back-to-back requests too.
- R3: With `req_dir` = 0, the registered result is P·Q^N mod 2^W. Entries are packed with entry k in bits [k·W +: W], where k=0 is row 0/column 0, k=1 is row 0/column 1, k=2 is row 1/column 0 and k=3 is row 1/column 1.
- R4: With `req_dir` = 1, the registered result is C·Q^-N mod 2^W, using the same packing.
- R5: Feeding an encryption result back in with `req_dir` = 1 returns the original block bit for bit.
- R6: In a cycle with `req_valid` = 0, `req_dir` and `req_block` are ignored and `res_block` keeps its value.
- R7: For N = 1, encryption yields [[a+b, a], [c+d, c]] for input [[a, b], [c, d]].
- R8: Products and sums wrap modulo 2^W, including for all-ones inputs and for values of N whose Fibonacci numbers exceed 2^W.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | A block is presented this cycle |
| req_dir | input | 1 | 0 = encrypt, 1 = decrypt |
| req_block | input | 4*W | Input matrix, four packed W-bit entries |
| res_valid | output | 1 | Result register holds a new block |
| res_block | output | 4*W | Result matrix, four packed W-bit entries |

## Verification
Every result is due in the first clock edge after the edge that accepts its request. The bench drives inputs on falling edges and reads the outputs on the next falling edge, which falls half a period after that rising edge. The bench then holds `req_valid` low for one more cycle while it drives junk on the data and direction inputs, and checks on the following falling edge that the valid flag has dropped and the result is unchanged. A back-to-back pair checks that each output is due one edge after its own request, not after the last request. Expected values come from plain multiplication for three build-time powers (1, 10 and 30). N = 30 makes the constants wrap modulo 2^16.

// File: rtl/fqm_pkg.sv
package fqm_pkg;

   localparam int MAX_W = 64;
   localparam int MAX_N = 4096;

   typedef struct packed {
      logic [MAX_W-1:0] pos;
      logic [MAX_W-1:0] neg;
   } csd_t;

   // Fibonacci number F(n), wrapped modulo 2^64
   function automatic logic [MAX_W-1:0] fib(input int n);
      logic [MAX_W-1:0] lo, hi, nx;
      lo = '0;
      hi = 64'd1;
      for (int i = 0; i < n; i++) begin
         nx = lo + hi;
         lo = hi;
         hi = nx;
      end
      return lo;
   endfunction

   function automatic logic [MAX_W-1:0] negate(input logic [MAX_W-1:0] v);
      return ~v + 64'd1;
   endfunction

   // forward matrix entry, index = row*2 + col
   function automatic logic [MAX_W-1:0] fwd_k(input int n, input int idx);
      case (idx)
         0:       return fib(n + 1);
         3:       return fib(n - 1);
         default: return fib(n);
      endcase
   endfunction

   // inverse matrix entry, sign (-1)^n folded in
   function automatic logic [MAX_W-1:0] inv_k(input int n, input int idx);
      logic [MAX_W-1:0] v;
      case (idx)
         0:       v = fib(n - 1);
         3:       v = fib(n + 1);
         default: v = negate(fib(n));
      endcase
      return (n % 2 == 1) ? negate(v) : v;
   endfunction

   // signed-digit recoding with no two adjacent nonzero digits;
   // digits at weight 2^w and above vanish modulo 2^w
   function automatic csd_t csd_recode(input logic [MAX_W-1:0] k, input int w);
      logic [MAX_W+1:0] x;
      csd_t d;
      d = '0;
      x = {2'b00, k};
      for (int i = 0; i < MAX_W; i++) begin
         if (i < w) begin
            if (x[0]) begin
               if (x[1]) begin
                  d.neg[i] = 1'b1;
                  x = x + 66'd1;
               end else begin
                  d.pos[i] = 1'b1;
                  x = x - 66'd1;
               end
            end
            x = x >> 1;
         end
      end
      return d;
   endfunction

endpackage

// File: rtl/fqm_csd_mult.sv
module fqm_csd_mult #(
   parameter int               W = 16,
   parameter logic [63:0]      K = 64'd0
) (
   input  logic [W-1:0] x,
   output logic [W-1:0] y
);

   localparam fqm_pkg::csd_t DIG = fqm_pkg::csd_recode(K, W);

   logic [W-1:0] term [W];

   for (genvar i = 0; i < W; i++) begin : g_dig
      if (DIG.pos[i]) begin : g_add
         assign term[i] = x << i;
      end else if (DIG.neg[i]) begin : g_sub
         assign term[i] = '0 - (x << i);
      end else begin : g_zero
         assign term[i] = '0;
      end
   end

   always_comb begin
      y = '0;
      for (int i = 0; i < W; i++) begin
         y = y + term[i];
      end
   end

endmodule

// File: rtl/fqm_mat_mul.sv
module fqm_mat_mul #(
   parameter int          W   = 16,
   parameter logic [63:0] K00 = 64'd1,
   parameter logic [63:0] K01 = 64'd0,
   parameter logic [63:0] K10 = 64'd0,
   parameter logic [63:0] K11 = 64'd1
) (
   input  logic [4*W-1:0] blk,
   output logic [4*W-1:0] res
);

   for (genvar r = 0; r < 2; r++) begin : g_row
      for (genvar c = 0; c < 2; c++) begin : g_col
         localparam logic [63:0] KA = (c == 0) ? K00 : K01;
         localparam logic [63:0] KB = (c == 0) ? K10 : K11;
         logic [W-1:0] pa, pb;

         fqm_csd_mult #(.W(W), .K(KA)) u_pa (
            .x (blk[(2*r)*W +: W]),
            .y (pa)
         );
         fqm_csd_mult #(.W(W), .K(KB)) u_pb (
            .x (blk[(2*r+1)*W +: W]),
            .y (pb)
         );

         assign res[(2*r+c)*W +: W] = pa + pb;
      end
   end

endmodule

// File: rtl/fqm_cipher.sv
module fqm_cipher #(
   parameter int W = 16,
   parameter int N = 10
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           req_valid,
   input  logic           req_dir,
   input  logic [4*W-1:0] req_block,
   output logic           res_valid,
   output logic [4*W-1:0] res_block
);

   localparam int BLK_W = 4 * W;

   if (W < 2 || W > fqm_pkg::MAX_W) begin : g_bad_w
      $error("fqm_cipher: W must lie in 2..64");
   end
   if (N < 1 || N > fqm_pkg::MAX_N) begin : g_bad_n
      $error("fqm_cipher: N must lie in 1..4096");
   end

   logic [BLK_W-1:0] fwd_res, inv_res;

   fqm_mat_mul #(
      .W   (W),
      .K00 (fqm_pkg::fwd_k(N, 0)),
      .K01 (fqm_pkg::fwd_k(N, 1)),
      .K10 (fqm_pkg::fwd_k(N, 2)),
      .K11 (fqm_pkg::fwd_k(N, 3))
   ) u_fwd (
      .blk (req_block),
      .res (fwd_res)
   );

   fqm_mat_mul #(
      .W   (W),
      .K00 (fqm_pkg::inv_k(N, 0)),
      .K01 (fqm_pkg::inv_k(N, 1)),
      .K10 (fqm_pkg::inv_k(N, 2)),
      .K11 (fqm_pkg::inv_k(N, 3))
   ) u_inv (
      .blk (req_block),
      .res (inv_res)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         res_block <= '0;
      end else begin
         res_valid <= req_valid;
         if (req_valid) begin
            res_block <= req_dir ? inv_res : fwd_res;
         end
      end
   end

endmodule

// File: rtl/fqm_cipher_chk.sv
module fqm_cipher_chk #(
   parameter int W = 16,
   parameter int N = 10
) (
   input logic           clk,
   input logic           rst_n,
   input logic           req_valid,
   input logic           req_dir,
   input logic [4*W-1:0] req_block,
   input logic           res_valid,
   input logic [4*W-1:0] res_block
);

   localparam logic [W-1:0] F00 = W'(fqm_pkg::fwd_k(N, 0));
   localparam logic [W-1:0] F01 = W'(fqm_pkg::fwd_k(N, 1));
   localparam logic [W-1:0] F10 = W'(fqm_pkg::fwd_k(N, 2));
   localparam logic [W-1:0] F11 = W'(fqm_pkg::fwd_k(N, 3));
   localparam logic [W-1:0] I00 = W'(fqm_pkg::inv_k(N, 0));
   localparam logic [W-1:0] I01 = W'(fqm_pkg::inv_k(N, 1));
   localparam logic [W-1:0] I10 = W'(fqm_pkg::inv_k(N, 2));
   localparam logic [W-1:0] I11 = W'(fqm_pkg::inv_k(N, 3));

   function automatic logic [4*W-1:0] mul_ref(
      input logic [4*W-1:0] b,
      input logic [W-1:0] k00, input logic [W-1:0] k01,
      input logic [W-1:0] k10, input logic [W-1:0] k11);
      logic [4*W-1:0] o;
      o[0*W +: W] = b[0*W +: W] * k00 + b[1*W +: W] * k10;
      o[1*W +: W] = b[0*W +: W] * k01 + b[1*W +: W] * k11;
      o[2*W +: W] = b[2*W +: W] * k00 + b[3*W +: W] * k10;
      o[3*W +: W] = b[2*W +: W] * k01 + b[3*W +: W] * k11;
      return o;
   endfunction

   logic [4*W-1:0] ref_fwd, ref_inv;
   assign ref_fwd = mul_ref(req_block, F00, F01, F10, F11);
   assign ref_inv = mul_ref(req_block, I00, I01, I10, I11);

   p_valid_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> res_valid);

   p_valid_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !res_valid);

   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> $stable(res_block));

   p_fwd_result_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_dir) |=> (res_block == $past(ref_fwd)));

   p_inv_result_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_dir) |=> (res_block == $past(ref_inv)));

endmodule

bind fqm_cipher fqm_cipher_chk #(.W(W), .N(N)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_dir   (req_dir),
   .req_block (req_block),
   .res_valid (res_valid),
   .res_block (res_block)
);

// File: tb/fqm_cipher_bench.sv
`timescale 1ns/100ps
module fqm_cipher_bench;

   localparam int BW  = 16;
   localparam int BLK = 4 * BW;
   localparam int NI  = 3;
   localparam int NS [NI] = '{10, 1, 30};

   logic           clk = 1'b0;
   logic           rst_n;
   logic           req_valid;
   logic           req_dir;
   logic [BLK-1:0] req_blk  [NI];
   logic [BLK-1:0] res_blk  [NI];
   logic           res_vld  [NI];
   logic [BLK-1:0] stage    [NI];
   logic [BLK-1:0] got      [NI];

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   fqm_cipher #(.W(BW), .N(10)) u_fqm_cipher (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_dir(req_dir),
      .req_block(req_blk[0]), .res_valid(res_vld[0]), .res_block(res_blk[0]));
   fqm_cipher #(.W(BW), .N(1)) u_fqm_cipher_n1 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_dir(req_dir),
      .req_block(req_blk[1]), .res_valid(res_vld[1]), .res_block(res_blk[1]));
   fqm_cipher #(.W(BW), .N(30)) u_fqm_cipher_n30 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_dir(req_dir),
      .req_block(req_blk[2]), .res_valid(res_vld[2]), .res_block(res_blk[2]));

   function automatic logic [BW-1:0] fib16(input int n);
      logic [BW-1:0] a, b, t;
      a = '0;
      b = 16'd1;
      for (int i = 0; i < n; i++) begin
         t = a + b;
         a = b;
         b = t;
      end
      return a;
   endfunction

   function automatic logic [BLK-1:0] mul2(input logic [BLK-1:0] p,
      input logic [BW-1:0] k00, input logic [BW-1:0] k01,
      input logic [BW-1:0] k10, input logic [BW-1:0] k11);
      logic [BW-1:0] a, b, c, d, o0, o1, o2, o3;
      a = p[0 +: BW]; b = p[BW +: BW]; c = p[2*BW +: BW]; d = p[3*BW +: BW];
      o0 = a * k00 + b * k10;
      o1 = a * k01 + b * k11;
      o2 = c * k00 + d * k10;
      o3 = c * k01 + d * k11;
      return {o3, o2, o1, o0};
   endfunction

   function automatic logic [BLK-1:0] enc_ref(input logic [BLK-1:0] p, input int n);
      return mul2(p, fib16(n + 1), fib16(n), fib16(n), fib16(n - 1));
   endfunction

   function automatic logic [BLK-1:0] dec_ref(input logic [BLK-1:0] p, input int n);
      logic [BW-1:0] s00, s01, s11;
      s00 = fib16(n - 1);
      s01 = 16'd0 - fib16(n);
      s11 = fib16(n + 1);
      if (n % 2 == 1) begin
         s00 = 16'd0 - s00;
         s01 = 16'd0 - s01;
         s11 = 16'd0 - s11;
      end
      return mul2(p, s00, s01, s01, s11);
   endfunction

   task automatic check(input string tag, input logic [BLK-1:0] act, input logic [BLK-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
   endtask

   // one request, result read one edge later, then an idle cycle with junk inputs
   task automatic apply(input bit dir);
      @(negedge clk);
      req_valid = 1'b1;
      req_dir   = dir;
      for (int k = 0; k < NI; k++) req_blk[k] = stage[k];
      @(negedge clk);
      for (int k = 0; k < NI; k++) begin
         check("R2 valid after request", {63'd0, res_vld[k]}, 64'd1);
         got[k] = res_blk[k];
      end
      req_valid = 1'b0;
      req_dir   = ~dir;
      for (int k = 0; k < NI; k++) req_blk[k] = {$urandom(), $urandom()};
      @(negedge clk);
      for (int k = 0; k < NI; k++) begin
         check("R2 valid low when idle", {63'd0, res_vld[k]}, 64'd0);
         check("R6 result held while idle", res_blk[k], got[k]);
      end
   endtask

   initial begin
      repeat (60000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: got timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      logic [BLK-1:0] p, q, a1, b1;
      logic [BLK-1:0] enc_got [NI];
      void'($urandom(32'h1f2e3d4c));
      rst_n = 1'b0;
      req_valid = 1'b0;
      req_dir = 1'b0;
      for (int k = 0; k < NI; k++) req_blk[k] = '0;
      repeat (3) @(negedge clk);
      for (int k = 0; k < NI; k++) begin
         check("R1 reset valid", {63'd0, res_vld[k]}, 64'd0);
         check("R1 reset block", res_blk[k], '0);
      end
      rst_n = 1'b1;
      @(negedge clk);
      for (int k = 0; k < NI; k++) begin
         check("R1 valid after reset", {63'd0, res_vld[k]}, 64'd0);
         check("R1 block after reset", res_blk[k], '0);
      end

      // directed: zero block, all-ones block (R8), single unit entry
      p = '0;
      for (int k = 0; k < NI; k++) stage[k] = p;
      apply(1'b0);
      for (int k = 0; k < NI; k++) check("R3 zero block", got[k], '0);

      p = '1;
      for (int k = 0; k < NI; k++) stage[k] = p;
      apply(1'b0);
      for (int k = 0; k < NI; k++) begin
         check("R8 all-ones encrypt wrap", got[k], enc_ref(p, NS[k]));
         enc_got[k] = got[k];
      end
      for (int k = 0; k < NI; k++) stage[k] = enc_got[k];
      apply(1'b1);
      for (int k = 0; k < NI; k++) check("R8 all-ones round trip", got[k], p);

      p = 64'h0000_0000_0001_0000;
      for (int k = 0; k < NI; k++) stage[k] = p;
      apply(1'b1);
      for (int k = 0; k < NI; k++) check("R4 unit entry decrypt", got[k], dec_ref(p, NS[k]));

      // R7: N = 1 gives [[a+b, a], [c+d, c]]
      p = 64'h1234_fedc_8001_7fff;
      for (int k = 0; k < NI; k++) stage[k] = p;
      apply(1'b0);
      check("R7 n1 formula", got[1],
            {p[2*BW +: BW], p[3*BW +: BW] + p[2*BW +: BW],
             p[0 +: BW], p[BW +: BW] + p[0 +: BW]});

      // R2: back-to-back requests
      a1 = {$urandom(), $urandom()};
      b1 = {$urandom(), $urandom()};
      @(negedge clk);
      req_valid = 1'b1;
      req_dir = 1'b0;
      for (int k = 0; k < NI; k++) req_blk[k] = a1;
      @(negedge clk);
      req_dir = 1'b1;
      for (int k = 0; k < NI; k++) req_blk[k] = b1;
      for (int k = 0; k < NI; k++) check("R2 burst first result", res_blk[k], enc_ref(a1, NS[k]));
      @(negedge clk);
      req_valid = 1'b0;
      for (int k = 0; k < NI; k++) begin
         check("R2 burst second valid", {63'd0, res_vld[k]}, 64'd1);
         check("R2 burst second result", res_blk[k], dec_ref(b1, NS[k]));
      end
      @(negedge clk);
      for (int k = 0; k < NI; k++) check("R2 burst ends", {63'd0, res_vld[k]}, 64'd0);

      // constrained random: encrypt, decrypt back, independent decrypt
      for (int it = 0; it < 40; it++) begin
         p = {$urandom(), $urandom()};
         if (it % 8 == 0) p[BW-1:0] = 16'hffff;
         for (int k = 0; k < NI; k++) stage[k] = p;
         apply(1'b0);
         for (int k = 0; k < NI; k++) begin
            check("R3 random encrypt", got[k], enc_ref(p, NS[k]));
            enc_got[k] = got[k];
         end
         for (int k = 0; k < NI; k++) stage[k] = enc_got[k];
         apply(1'b1);
         for (int k = 0; k < NI; k++) check("R5 round trip", got[k], p);
         q = {$urandom(), $urandom()};
         for (int k = 0; k < NI; k++) stage[k] = q;
         apply(1'b1);
         for (int k = 0; k < NI; k++) check("R4 random decrypt", got[k], dec_ref(q, NS[k]));
      end

      done = 1'b1;
      summary();
      $finish;
   end

endmodule